// File: doc/BRIEF.md
# LDPC Iteration Phase Sequencer

This block is the controller of a memory-based LDPC decoder. It does no node arithmetic. It walks the decoder through a load phase, then through pairs of check and variable phases. It drives the enables and addresses of three dual-port memories:
- the channel-LLR store,
- the check-result store,
- the variable-result store.

It also counts iterations and marks the decoded word when decoding finishes.

Addresses come from two external lookup tables. The block drives a check-side index and a variable-side index, and each table returns an address for that index. The variable-side index is used in two phases. During the load it places each channel LLR in both the LLR store and the variable-result store. During each variable phase it sets the reads and the write-back. Each memory port carries two samples per clock, so every phase length is a parameter that counts clocks, not edges. Decoding always runs the full iteration count. The total busy time is the load time plus the sum of the check-phase and variable-phase times, multiplied by the iteration count.

Top module: `ldpc_phase_seq`

## Requirements
- R1: After reset the block is idle. `phase_o` is 0, `busy_o` is low, and every memory enable, `dec_valid_o` and `done_o` are low.
- R2: A `start_i` sampled high while idle moves the block to the load phase (`phase_o`=1) on the next cycle. This phase lasts `INIT_LEN` cycles. In it, `llr_we_o` and `varm_we_o` are both high, both stores are addressed by `var_addr_i`, and `var_idx_o` counts 0 to `INIT_LEN`-1.
- R3: The check phase (`phase_o`=2) lasts `CHK_LEN` cycles. In it, `varm_re_o` and `chkm_we_o` are high, both the check-result and variable-result addresses equal `chk_addr_i`, and `chk_idx_o` counts 0 to `CHK_LEN`-1.
- R4: The variable phase (`phase_o`=3) lasts `VAR_LEN` cycles. In it, `llr_re_o` and `chkm_re_o` are high, all three addresses equal `var_addr_i`, and `var_idx_o` counts 0 to `VAR_LEN`-1. In every iteration except the last, `varm_we_o` is high.
- R5: In the variable phase of the last iteration, `dec_valid_o` is high on every cycle and `varm_we_o` stays low.
- R6: The load phase is followed by a check phase. Each variable phase is followed by a new check phase until `MAX_ITER` iterations are done. `iter_o` shows the 0-based index of the current iteration and never reaches `MAX_ITER`.
- R7: `done_o` is a one-cycle pulse on the last `dec_valid_o` cycle. The block is idle on the next cycle. The busy time is exactly `INIT_LEN + (CHK_LEN+VAR_LEN)*MAX_ITER` cycles.
- R8: A `start_i` pulse while busy has no effect. The phase sequence, its length and the single `done_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a decode (accepted only when idle) |
| chk_addr_i | input | ADDR_W | Check-side table address for `chk_idx_o` |
| var_addr_i | input | ADDR_W | Variable-side table address for `var_idx_o` |
| chk_idx_o | output | IDX_W | Check-side table index |
| var_idx_o | output | IDX_W | Variable-side table index |
| phase_o | output | 2 | 0 idle, 1 load, 2 check, 3 variable |
| iter_o | output | ITER_W | Current iteration, 0-based |
| busy_o | output | 1 | Decode in progress |
| llr_addr_o | output | ADDR_W | LLR store address |
| llr_we_o | output | 1 | LLR store write enable |
| llr_re_o | output | 1 | LLR store read enable |
| chkm_addr_o | output | ADDR_W | Check-result store address |
| chkm_we_o | output | 1 | Check-result store write enable |
| chkm_re_o | output | 1 | Check-result store read enable |
| varm_addr_o | output | ADDR_W | Variable-result store address |
| varm_we_o | output | 1 | Variable-result store write enable |
| varm_re_o | output | 1 | Variable-result store read enable |
| dec_valid_o | output | 1 | Decision output valid |
| done_o | output | 1 | Decode finished (one cycle) |

## Verification
The bench builds the block with `INIT_LEN`=6, `CHK_LEN`=4, `VAR_LEN`=5, `MAX_ITER`=3 and `ADDR_W`=5. With these values a whole decode takes 33 cycles. The bench can therefore compare every cycle of every phase, including the switch from non-final to final variable phases and the done pulse. The lengths are unequal, so a counter that wraps at the wrong limit or reuses the wrong length for the shared variable-side index shows up at once. The address tables are distinct affine maps, so any mixing of check-side and variable-side addresses is visible.

// File: rtl/ldpc_seq_pkg.sv
package ldpc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_CHK  = 2'd2,
    PH_VAR  = 2'd3
  } phase_e;
endpackage

// File: rtl/seq_idx_cnt.sv
module seq_idx_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == lim_i - W'(1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= wrap_o ? '0 : cnt_q + W'(1);
  end

  p_idx_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q < lim_i);
endmodule

// File: rtl/seq_port_ctl.sv
module seq_port_ctl
  import ldpc_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  phase_e            phase_i,
  input  logic              final_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [ADDR_W-1:0] var_addr_i,
  output logic [ADDR_W-1:0] llr_addr_o,
  output logic              llr_we_o,
  output logic              llr_re_o,
  output logic [ADDR_W-1:0] chkm_addr_o,
  output logic              chkm_we_o,
  output logic              chkm_re_o,
  output logic [ADDR_W-1:0] varm_addr_o,
  output logic              varm_we_o,
  output logic              varm_re_o,
  output logic              dec_valid_o
);
  logic in_chk;
  assign in_chk = (phase_i == PH_CHK);

  // check side owns both check and variable stores only in the check phase
  assign llr_addr_o  = var_addr_i;
  assign chkm_addr_o = in_chk ? chk_addr_i : var_addr_i;
  assign varm_addr_o = in_chk ? chk_addr_i : var_addr_i;

  always_comb begin
    llr_we_o    = 1'b0;
    llr_re_o    = 1'b0;
    chkm_we_o   = 1'b0;
    chkm_re_o   = 1'b0;
    varm_we_o   = 1'b0;
    varm_re_o   = 1'b0;
    dec_valid_o = 1'b0;
    unique case (phase_i)
      PH_LOAD: begin
        llr_we_o  = 1'b1;
        varm_we_o = 1'b1;
      end
      PH_CHK: begin
        varm_re_o = 1'b1;
        chkm_we_o = 1'b1;
      end
      PH_VAR: begin
        llr_re_o    = 1'b1;
        chkm_re_o   = 1'b1;
        varm_we_o   = !final_i;
        dec_valid_o = final_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ldpc_phase_seq.sv
module ldpc_phase_seq
  import ldpc_seq_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int INIT_LEN = 2048,
  parameter int CHK_LEN  = 8192,
  parameter int VAR_LEN  = 7168,
  parameter int MAX_ITER = 25,
  localparam int MAX_LEN = (INIT_LEN > CHK_LEN) ?
                           ((INIT_LEN > VAR_LEN) ? INIT_LEN : VAR_LEN) :
                           ((CHK_LEN > VAR_LEN) ? CHK_LEN : VAR_LEN),
  localparam int IDX_W   = $clog2(MAX_LEN + 1),
  localparam int ITER_W  = $clog2(MAX_ITER + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [ADDR_W-1:0] var_addr_i,
  output logic [IDX_W-1:0]  chk_idx_o,
  output logic [IDX_W-1:0]  var_idx_o,
  output logic [1:0]        phase_o,
  output logic [ITER_W-1:0] iter_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] llr_addr_o,
  output logic              llr_we_o,
  output logic              llr_re_o,
  output logic [ADDR_W-1:0] chkm_addr_o,
  output logic              chkm_we_o,
  output logic              chkm_re_o,
  output logic [ADDR_W-1:0] varm_addr_o,
  output logic              varm_we_o,
  output logic              varm_re_o,
  output logic              dec_valid_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0]  INIT_L = IDX_W'(INIT_LEN);
  localparam logic [IDX_W-1:0]  CHK_L  = IDX_W'(CHK_LEN);
  localparam logic [IDX_W-1:0]  VAR_L  = IDX_W'(VAR_LEN);
  localparam logic [ITER_W-1:0] LAST_IT = ITER_W'(MAX_ITER - 1);

  phase_e            state_q, state_d;
  logic [ITER_W-1:0] iter_q;
  logic              chk_wrap, var_wrap, final_it;
  logic              var_en, chk_en, cnt_clr;
  logic [IDX_W-1:0]  var_lim;

  assign final_it = (iter_q == LAST_IT);
  assign var_en   = (state_q == PH_LOAD) || (state_q == PH_VAR);
  assign chk_en   = (state_q == PH_CHK);
  assign cnt_clr  = (state_q == PH_IDLE);
  assign var_lim  = (state_q == PH_LOAD) ? INIT_L : VAR_L;

  // variable-side index shared by load and variable phases
  seq_idx_cnt #(.W(IDX_W)) i_var_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .en_i(var_en), .lim_i(var_lim),
    .cnt_o(var_idx_o), .wrap_o(var_wrap)
  );

  seq_idx_cnt #(.W(IDX_W)) i_chk_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .en_i(chk_en), .lim_i(CHK_L),
    .cnt_o(chk_idx_o), .wrap_o(chk_wrap)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (start_i)  state_d = PH_LOAD;
      PH_LOAD: if (var_wrap) state_d = PH_CHK;
      PH_CHK:  if (chk_wrap) state_d = PH_VAR;
      PH_VAR:  if (var_wrap) state_d = final_it ? PH_IDLE : PH_CHK;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == PH_IDLE)                         iter_q <= '0;
      else if (state_q == PH_VAR && var_wrap && !final_it) iter_q <= iter_q + ITER_W'(1);
    end
  end

  seq_port_ctl #(.ADDR_W(ADDR_W)) i_port_ctl (
    .phase_i(state_q), .final_i(final_it),
    .chk_addr_i, .var_addr_i,
    .llr_addr_o, .llr_we_o, .llr_re_o,
    .chkm_addr_o, .chkm_we_o, .chkm_re_o,
    .varm_addr_o, .varm_we_o, .varm_re_o,
    .dec_valid_o
  );

  assign phase_o = state_q;
  assign iter_o  = iter_q;
  assign busy_o  = (state_q != PH_IDLE);
  assign done_o  = (state_q == PH_VAR) && var_wrap && final_it;

  p_iter_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_q < ITER_W'(MAX_ITER));
  p_final_no_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> !varm_we_o);
  p_done_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> dec_valid_o);
  p_idle_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> busy_o);
  p_chk_port_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chkm_we_o && chkm_re_o));
endmodule

// File: tb/test_ldpc_phase_seq.sv
module test_ldpc_phase_seq;
  localparam int AW = 5, IL = 6, CL = 4, VL = 5, MI = 3;
  localparam int TOTAL = IL + (CL + VL) * MI;
  localparam int IW = $clog2(6 + 1);
  localparam int TW = $clog2(MI + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] chk_addr, var_addr, llr_a, chkm_a, varm_a;
  logic [IW-1:0] chk_idx, var_idx;
  logic [1:0] phase;
  logic [TW-1:0] iter;
  logic busy, llr_we, llr_re, chkm_we, chkm_re, varm_we, varm_re, dvld, done;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  function automatic int chk_tab(int i); return (i * 7 + 3) % 32; endfunction
  function automatic int var_tab(int i); return (i * 11 + 5) % 32; endfunction
  assign chk_addr = AW'(chk_tab(int'(chk_idx)));
  assign var_addr = AW'(var_tab(int'(var_idx)));

  ldpc_phase_seq #(.ADDR_W(AW), .INIT_LEN(IL), .CHK_LEN(CL), .VAR_LEN(VL), .MAX_ITER(MI))
  i_ldpc_phase_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .chk_addr_i(chk_addr), .var_addr_i(var_addr),
    .chk_idx_o(chk_idx), .var_idx_o(var_idx), .phase_o(phase), .iter_o(iter),
    .busy_o(busy), .llr_addr_o(llr_a), .llr_we_o(llr_we), .llr_re_o(llr_re),
    .chkm_addr_o(chkm_a), .chkm_we_o(chkm_we), .chkm_re_o(chkm_re),
    .varm_addr_o(varm_a), .varm_we_o(varm_we), .varm_re_o(varm_re),
    .dec_valid_o(dvld), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int en_vec();
    return {24'd0, llr_we, llr_re, chkm_we, chkm_re, varm_we, varm_re, dvld, done};
  endfunction

  task automatic check_idle(input string tag);
    chk(phase == 2'd0 && !busy && en_vec() == 0, tag, {phase, busy, en_vec()}, 0);
  endtask

  // cycle k counts from the first busy cycle
  task automatic check_cycle(input int k);
    int ph, idx, it, ev, a;
    bit fin;
    if (k < IL) begin
      ph = 1; idx = k; it = 0;
      ev = 8'b1000_1000; a = var_tab(idx);
      chk(ev == en_vec(), "R2 load enables", en_vec(), ev);
      chk(llr_a == AW'(a) && varm_a == AW'(a) && int'(var_idx) == idx,
          "R2 load address", {llr_a, varm_a}, {a[4:0], a[4:0]});
      chk(int'(phase) == ph, "R2 load phase", phase, ph);
    end else begin
      it = (k - IL) / (CL + VL);
      idx = (k - IL) % (CL + VL);
      fin = (it == MI - 1);
      if (idx < CL) begin
        ev = 8'b0010_0100; a = chk_tab(idx);
        chk(ev == en_vec(), "R3 check enables", en_vec(), ev);
        chk(chkm_a == AW'(a) && varm_a == AW'(a) && int'(chk_idx) == idx,
            "R3 check address", {chkm_a, varm_a}, {a[4:0], a[4:0]});
        chk(int'(phase) == 2 && int'(iter) == it, "R6 check phase/iter", {phase, iter}, {2'(2), TW'(it)});
      end else begin
        idx -= CL; a = var_tab(idx);
        ev = {1'b0, 1'b1, 1'b0, 1'b1, !fin, 1'b0, fin, fin && idx == VL - 1};
        chk(ev == en_vec(), fin ? "R5 R7 final var enables" : "R4 var enables", en_vec(), ev);
        chk(llr_a == AW'(a) && chkm_a == AW'(a) && varm_a == AW'(a) && int'(var_idx) == idx,
            "R4 var address", {llr_a, chkm_a, varm_a}, a);
        chk(int'(phase) == 3 && int'(iter) == it, "R6 var phase/iter", {phase, iter}, {2'(3), TW'(it)});
      end
    end
  endtask

  task automatic run_decode(input bit poke);
    int dones = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < TOTAL; k++) begin
      check_cycle(k);
      dones += int'(done);
      if (poke) start = (k == 10 || k == 20 || k == TOTAL - 2);
      @(negedge clk);
    end
    start = 1'b0;
    chk(dones == 1, poke ? "R8 single done" : "R7 single done", dones, 1);
    check_idle(poke ? "R8 idle after busy window" : "R7 idle after done");
  endtask

  task automatic t_reset();
    #35; check_idle("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk); check_idle("R1 idle after reset");
  endtask

  task automatic t_no_start();
    repeat (3) @(negedge clk);
    check_idle("R1 stays idle without start");
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_no_start();
    run_decode(1'b0);
    run_decode(1'b1);
    run_decode(1'b0);
    finish_run();
  end
endmodule